// File: doc/BRIEF.md
# CCD Line Pixel Framer

This block sits right after the converters of a two-output colour line sensor. It receives one digitised word per pixel period from each output: the green output and the output that alternates red and blue. A pixel strobe marks each sample, and a line-start flag marks the first sample of every line. The block counts the positions in each line and sorts every position into one of three kinds: leading dummy or optical black, effective, or trailing dummy. It measures the dark level of each channel from a fixed window of eight dummy positions near the start of the line. It then removes that dark level from the effective samples of the same line.

The output is three streams: green, red and blue. Each has its own valid flag, its own start-of-line and end-of-line markers, and corrected data that clamps at zero. A line that is cut short by an early line-start raises a framing-error flag that stays set, and the counter then starts again from the new line. Samples that arrive after a full line and before the next line-start are dropped.

Top module: `ccd_line_framer`

## Requirements
- R1: While reset is held and after it is released, every valid flag, every line marker and `frame_err` are low until a line is driven.
- R2: A line has 2094 positions. Position 0 is the sample whose `pix_valid` and `line_start` are both high. Positions 32 to 2079 are effective. Each effective position gives exactly one green output, 2048 per full line, in input order. The output appears one clock after the sample is taken.
- R3: The red/blue samples are split by effective offset k (position minus 32). Even k goes to the red stream and odd k to the blue stream, giving 1024 of each per full line. Red and blue are never valid in the same cycle.
- R4: For each line, the green dark level is floor((sum of the green samples at positions 2 to 9) / 8). The red/blue dark level is formed the same way from the red/blue samples and is used by both red and blue.
- R5: Each corrected output equals the sample minus its channel's dark level, or 0 when the sample is below the dark level.
- R6: Green start-of-line marks k=0 and green end-of-line marks k=2047. Red markers are at k=0 and k=2046. Blue markers are at k=1 and k=2047. A marker is only ever high together with its stream's valid flag.
- R7: Positions 0 to 31 and 2080 to 2093 give no output. A sample strobed after position 2093 without `line_start` gives no output and does not advance the count.
- R8: A cycle with `pix_valid` low advances nothing, and no output is valid in the cycle after it.
- R9: A `line_start` that arrives before 2094 positions of the current line have been taken sets `frame_err`. The flag stays set until reset. The new sample becomes position 0.
- R10: The dark level measured on a line is applied to that line's own effective samples, so a change of dark level between lines takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | A sample is present this cycle |
| line_start | input | 1 | This sample is position 0 of a line |
| g_in | input | DW | Green sample |
| rb_in | input | DW | Alternating red/blue sample |
| g_valid | output | 1 | Green output valid |
| g_data | output | DW | Corrected green |
| g_sol | output | 1 | First green of line |
| g_eol | output | 1 | Last green of line |
| r_valid | output | 1 | Red output valid |
| r_data | output | DW | Corrected red |
| r_sol | output | 1 | First red of line |
| r_eol | output | 1 | Last red of line |
| b_valid | output | 1 | Blue output valid |
| b_data | output | DW | Corrected blue |
| b_sol | output | 1 | First blue of line |
| b_eol | output | 1 | Last blue of line |
| frame_err | output | 1 | Sticky short-line flag |

## Verification
Every output is registered once, so each output for a sample taken at one clock edge is due at the next edge. The dark level is ready long before the first effective position. The driver changes inputs just after a rising edge, and the monitor compares outputs at the falling edge against scoreboard items queued by the driver in input order. That puts each comparison exactly one edge after its stimulus. The line totals and empty queues are checked three cycles after the last sample, which is past every due cycle. The monitor also remembers whether the previous cycle strobed a sample, so it can flag any output that follows an idle cycle.

// File: rtl/ccd_line_framer.sv
module ccd_line_framer #(
  parameter int DW        = 12,
  parameter int LINE_LEN  = 2094,
  parameter int PRE_LEN   = 32,
  parameter int EFF_LEN   = 2048,
  parameter int BLK_START = 2,
  parameter int BLK_SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          line_start,
  input  logic [DW-1:0] g_in,
  input  logic [DW-1:0] rb_in,
  output logic          g_valid,
  output logic [DW-1:0] g_data,
  output logic          g_sol,
  output logic          g_eol,
  output logic          r_valid,
  output logic [DW-1:0] r_data,
  output logic          r_sol,
  output logic          r_eol,
  output logic          b_valid,
  output logic [DW-1:0] b_data,
  output logic          b_sol,
  output logic          b_eol,
  output logic          frame_err
);
  localparam int CW = $clog2(LINE_LEN + 1);
  localparam int SW = DW + BLK_SHIFT;
  localparam logic [CW-1:0] LAST_POS = CW'(LINE_LEN);
  localparam logic [CW-1:0] BLK_LO   = CW'(BLK_START);
  localparam logic [CW-1:0] BLK_HI   = CW'(BLK_START + (1 << BLK_SHIFT) - 1);
  localparam logic [CW-1:0] EFF_LO   = CW'(PRE_LEN);
  localparam logic [CW-1:0] EFF_HI   = CW'(PRE_LEN + EFF_LEN - 1);
  localparam logic [CW-1:0] K_LAST   = CW'(EFF_LEN - 1);
  localparam logic [CW-1:0] K_PENULT = CW'(EFF_LEN - 2);

  logic [CW-1:0] cnt;
  logic          active;
  logic [SW-1:0] g_sum, rb_sum;
  logic [DW-1:0] g_blk, rb_blk;

  wire [CW-1:0] idx    = line_start ? '0 : cnt;
  wire          take   = pix_valid && (line_start || (active && cnt < LAST_POS));
  wire          in_blk = idx >= BLK_LO && idx <= BLK_HI;
  wire          is_eff = take && idx >= EFF_LO && idx <= EFF_HI;
  wire [CW-1:0] k      = idx - EFF_LO;

  wire [SW-1:0] g_acc  = g_sum + SW'(g_in);
  wire [SW-1:0] rb_acc = rb_sum + SW'(rb_in);
  wire [DW:0]   g_dif  = {1'b0, g_in} - {1'b0, g_blk};
  wire [DW:0]   rb_dif = {1'b0, rb_in} - {1'b0, rb_blk};
  wire [DW-1:0] g_cor  = g_dif[DW]  ? '0 : g_dif[DW-1:0];
  wire [DW-1:0] rb_cor = rb_dif[DW] ? '0 : rb_dif[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      active    <= 1'b0;
      frame_err <= 1'b0;
    end else if (take) begin
      cnt    <= idx + 1'b1;
      active <= 1'b1;
      if (line_start && active && cnt != LAST_POS) frame_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_sum  <= '0;
      rb_sum <= '0;
      g_blk  <= '0;
      rb_blk <= '0;
    end else if (take && in_blk) begin
      g_sum  <= (idx == BLK_LO) ? SW'(g_in)  : g_acc;
      rb_sum <= (idx == BLK_LO) ? SW'(rb_in) : rb_acc;
      if (idx == BLK_HI) begin
        g_blk  <= g_acc[SW-1:BLK_SHIFT];
        rb_blk <= rb_acc[SW-1:BLK_SHIFT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {g_valid, g_sol, g_eol} <= '0;
      {r_valid, r_sol, r_eol} <= '0;
      {b_valid, b_sol, b_eol} <= '0;
      g_data <= '0;
      r_data <= '0;
      b_data <= '0;
    end else begin
      g_valid <= is_eff;
      g_sol   <= is_eff && k == '0;
      g_eol   <= is_eff && k == K_LAST;
      r_valid <= is_eff && !k[0];
      r_sol   <= is_eff && k == '0;
      r_eol   <= is_eff && k == K_PENULT;
      b_valid <= is_eff && k[0];
      b_sol   <= is_eff && k == CW'(1);
      b_eol   <= is_eff && k == K_LAST;
      if (is_eff) begin
        g_data <= g_cor;
        if (k[0]) b_data <= rb_cor;
        else      r_data <= rb_cor;
      end
    end
  end
endmodule

// File: rtl/ccd_line_framer_chk.sv
module ccd_line_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic pix_valid,
  input logic g_valid,
  input logic g_sol,
  input logic g_eol,
  input logic r_valid,
  input logic r_sol,
  input logic r_eol,
  input logic b_valid,
  input logic b_sol,
  input logic b_eol,
  input logic frame_err
);
  // R3
  rb_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_valid && b_valid));

  // R6
  marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((g_sol || g_eol) |-> g_valid) and ((r_sol || r_eol) |-> r_valid)
    and ((b_sol || b_eol) |-> b_valid));

  // R8
  idle_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !(g_valid || r_valid || b_valid));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R2
  green_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g_valid |-> (r_valid || b_valid));
endmodule

bind ccd_line_framer ccd_line_framer_chk chk_i (.*);

// File: tb/ccd_line_framer_test.sv
module ccd_line_framer_test;
  localparam int DW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 1'b0, line_start = 1'b0;
  logic [DW-1:0] g_in = '0, rb_in = '0;
  logic g_valid, g_sol, g_eol, r_valid, r_sol, r_eol, b_valid, b_sol, b_eol, frame_err;
  logic [DW-1:0] g_data, r_data, b_data;

  always #2 clk = ~clk;

  ccd_line_framer uut (.*);

  typedef struct { int d; bit s; bit e; } item_t;
  item_t gq[$], rq[$], bq[$];
  int checks = 0, errors = 0;
  int gn = 0, rn = 0, bn = 0;
  bit prev_pv = 1'b0;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic pop_cmp(ref item_t q[$], input string nm, input int d, input bit s, input bit e);
    item_t it;
    if (q.size() == 0) begin
      chk(0, {"R7 unexpected output on ", nm}, d, -1);
      return;
    end
    it = q.pop_front();
    chk(d == it.d, {"R4 R5 R10 data on ", nm}, d, it.d);
    chk(s == it.s && e == it.e, {"R6 markers on ", nm}, {s, e}, {it.s, it.e});
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if ((g_valid || r_valid || b_valid) && !prev_pv)
        chk(0, "R8 output after idle cycle", 1, 0);
      if (g_valid) begin gn++; pop_cmp(gq, "green", g_data, g_sol, g_eol); end
      if (r_valid) begin rn++; pop_cmp(rq, "red",   r_data, r_sol, r_eol); end
      if (b_valid) begin bn++; pop_cmp(bq, "blue",  b_data, b_sol, b_eol); end
    end
    prev_pv = pix_valid;
  end

  function automatic int gval(int idx, int seed, int gd);
    if (idx >= 2 && idx <= 9) return gd + (idx * 5) % 7;
    if (idx < 32 || idx >= 2080) return 4000;
    if (idx - 32 < 3) return 1;
    return ((idx - 32) * 37 + seed) % 4096;
  endfunction

  function automatic int rbval(int idx, int seed, int rd);
    if (idx >= 2 && idx <= 9) return rd + (idx * 3) % 5;
    if (idx < 32 || idx >= 2080) return 3900;
    if (idx - 32 < 3) return 0;
    return ((idx - 32) * 53 + seed * 3) % 4096;
  endfunction

  task automatic drive_line(input int seed, input int gd, input int rd, input int npix, input int gap);
    int gdark = 0, rdark = 0;
    for (int i = 2; i <= 9; i++) begin
      gdark += gval(i, seed, gd);
      rdark += rbval(i, seed, rd);
    end
    gdark = gdark / 8;
    rdark = rdark / 8;
    for (int i = 0; i < npix; i++) begin
      int gv, rv, k;
      if (gap > 0 && i % gap == gap - 1) begin
        @(posedge clk); #1;
        pix_valid = 1'b0; line_start = 1'b0;
      end
      gv = gval(i, seed, gd);
      rv = rbval(i, seed, rd);
      k = i - 32;
      if (i >= 32 && i < 2080) begin
        item_t it;
        it.d = (gv > gdark) ? gv - gdark : 0; it.s = (k == 0); it.e = (k == 2047);
        gq.push_back(it);
        it.d = (rv > rdark) ? rv - rdark : 0;
        if (k % 2 == 0) begin it.s = (k == 0); it.e = (k == 2046); rq.push_back(it); end
        else            begin it.s = (k == 1); it.e = (k == 2047); bq.push_back(it); end
      end
      @(posedge clk); #1;
      pix_valid = 1'b1; line_start = (i == 0);
      g_in = DW'(gv); rb_in = DW'(rv);
    end
    @(posedge clk); #1;
    pix_valid = 1'b0; line_start = 1'b0;
  endtask

  task automatic end_check(input int eg, input int er, input int eb, input string tag);
    repeat (3) @(posedge clk);
    #1;
    chk(gn == eg, {"R2 green count ", tag}, gn, eg);
    chk(rn == er, {"R3 red count ", tag}, rn, er);
    chk(bn == eb, {"R3 blue count ", tag}, bn, eb);
    chk(gq.size() + rq.size() + bq.size() == 0, {"R2 R3 missing outputs ", tag},
        gq.size() + rq.size() + bq.size(), 0);
    gq.delete(); rq.delete(); bq.delete();
    gn = 0; rn = 0; bn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 outputs quiet in reset
    chk({g_valid, r_valid, b_valid, g_sol, g_eol, frame_err} == '0, "R1 during reset", 1, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk({g_valid, r_valid, b_valid, frame_err} == '0, "R1 after reset", 1, 0);

    drive_line(5, 200, 100, 2094, 0);
    // R7 extra strobes past the line end are dropped
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      pix_valid = 1'b1; line_start = 1'b0; g_in = 12'd3000; rb_in = 12'd3000;
    end
    @(posedge clk); #1;
    pix_valid = 1'b0;
    end_check(2048, 1024, 1024, "line1");
    chk(frame_err == 1'b0, "R9 no error on full line", frame_err, 0);

    // R8 gaps, R10 new higher dark level with many clamps
    drive_line(11, 900, 1500, 2094, 7);
    end_check(2048, 1024, 1024, "line2");
    chk(frame_err == 1'b0, "R9 no error before short line", frame_err, 0);

    // R9 short line then resync
    drive_line(3, 300, 400, 700, 0);
    end_check(668, 334, 334, "short");
    chk(frame_err == 1'b0, "R9 flag waits for next start", frame_err, 0);
    drive_line(9, 50, 60, 2094, 0);
    end_check(2048, 1024, 1024, "resync");
    chk(frame_err == 1'b1, "R9 sticky error set", frame_err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule